// File: doc/BRIEF.md
# Packing, Extension and Saturation Unit

This block is a single-issue integer media unit for a 32-bit processor datapath. Each request carries two source operands, a 5-bit shift amount with a shift-kind bit, a 2-bit byte-rotate field, a 5-bit clamp position and a 3-bit operation code. One cycle after the request it returns one 32-bit result together with a valid strobe.

The unit supports six operations:

- two halfword packs, each combining one half of the first operand with a shifted half of the second;
- an unsigned clamp of the pre-shifted second operand;
- three byte zero-extensions of the rotated second operand, the last of which adds its byte to the first operand.

Operation codes that are not assigned produce a zero result and raise a one-cycle illegal flag.

Top module: `media_pack_unit`

## Requirements
- R1: A synchronous reset clears the result to zero and holds `res_valid` and `illegal_op` low.
- R2: `res_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. Without a request, `res_q` keeps its last value.
- R3: Operation code 0 (halfword pack, low half kept) returns `src_a[15:0]` in bits 15:0. Bits 31:16 hold the upper half of `src_b` shifted left logically by `shamt`.
- R4: Operation code 1 (halfword pack, high half kept) returns `src_a[31:16]` in bits 31:16. Bits 15:0 hold the lower half of `src_b` shifted right arithmetically by `shamt`, where `shamt` = 0 means a shift of 32.
- R5: Operation code 2 (unsigned clamp) first shifts `src_b` by `shamt`. The shift is logical left when `shift_kind` = 0 and arithmetic right when `shift_kind` = 1.
- R6: Operation code 2 treats the shifted value as signed. It returns 0 for negative values, 2^`sat_pos`−1 for values above that bound, and the value itself otherwise.
- R7: The extension codes 3, 4 and 5 rotate `src_b` right by 8×`rot_sel` bits before they select any bytes.
- R8: Operation code 3 returns bits 7:0 of the rotated value, zero-extended. Operation code 4 returns bits 7:0 and 23:16 of the rotated value and clears all other bits.
- R9: Operation code 5 returns `src_a` plus the zero-extended bits 7:0 of the rotated value, modulo 2^32.
- R10: Operation codes 6 and 7 return zero and raise `illegal_op` for the result cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| shamt | input | 5 | Shift amount |
| shift_kind | input | 1 | Clamp pre-shift: 0 logical left, 1 arithmetic right |
| rot_sel | input | 2 | Byte rotate count for extensions |
| sat_pos | input | 5 | Clamp bit position |
| res_q | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe |
| illegal_op | output | 1 | Unassigned operation code seen |

## Verification
The hardest cases sit at the clamp boundaries. A left shift that overflows into the sign bit must produce 0 rather than the maximum. A position of 0 must clamp every positive value to 0, and a position of 31 must let 0x7FFFFFFF pass unchanged. The bench reaches these cases by choosing operands whose shifted value lands exactly on or just past the bound. It also drives the shift-of-32 case in the high-half pack with both sign polarities, and it sweeps all four rotations with a pattern whose bytes are distinct.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SHIFT_W = $clog2(DATA_W);
    localparam int unsigned OP_W    = 3;

    localparam logic [OP_W-1:0] OP_PACK_LO  = 3'd0;
    localparam logic [OP_W-1:0] OP_PACK_HI  = 3'd1;
    localparam logic [OP_W-1:0] OP_CLAMP    = 3'd2;
    localparam logic [OP_W-1:0] OP_ZX_BYTE  = 3'd3;
    localparam logic [OP_W-1:0] OP_ZX_PAIR  = 3'd4;
    localparam logic [OP_W-1:0] OP_ZX_ACC   = 3'd5;

    typedef enum logic [1:0] {
        XT_BYTE = 2'd0,
        XT_PAIR = 2'd1,
        XT_ACC  = 2'd2
    } xt_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]  res;
        logic               vld;
        logic               ill;
        logic [OP_W-1:0]    op;
        logic [SHIFT_W-1:0] pos;
    } unit_state_t;
endpackage

// File: rtl/mpu_pack.sv
module mpu_pack #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [W-1:0]         b_i,
    input  logic [$clog2(W)-1:0] sh_i,
    input  logic                 keep_hi_i,
    output logic [W-1:0]         y_o
);
    localparam int unsigned HALF = W / 2;

    logic [HALF-1:0] up_half_d;
    logic [HALF-1:0] dn_half_d;
    logic [W-1:0]    sra_d;

    always_comb begin
        up_half_d = HALF'((b_i << sh_i) >> HALF);
        if (sh_i == '0) begin
            sra_d = {W{b_i[W-1]}};
        end else begin
            sra_d = W'($signed(b_i) >>> sh_i);
        end
        dn_half_d = HALF'(sra_d);
        if (keep_hi_i) begin
            y_o = {a_i[W-1:HALF], dn_half_d};
        end else begin
            y_o = {up_half_d, a_i[HALF-1:0]};
        end
    end
endmodule

// File: rtl/mpu_clamp.sv
module mpu_clamp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         b_i,
    input  logic [$clog2(W)-1:0] sh_i,
    input  logic                 arith_i,
    input  logic [$clog2(W)-1:0] pos_i,
    output logic [W-1:0]         y_o
);
    logic [W-1:0] shifted_d;
    logic [W-1:0] limit_d;

    always_comb begin
        if (arith_i) begin
            shifted_d = W'($signed(b_i) >>> sh_i);
        end else begin
            shifted_d = b_i << sh_i;
        end
        limit_d = ({{(W-1){1'b0}}, 1'b1} << pos_i) - {{(W-1){1'b0}}, 1'b1};
        if (shifted_d[W-1]) begin
            y_o = '0;
        end else if (shifted_d > limit_d) begin
            y_o = limit_d;
        end else begin
            y_o = shifted_d;
        end
    end
endmodule

// File: rtl/mpu_extend.sv
module mpu_extend #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [1:0]       rot_i,
    input  mpu_pkg::xt_mode_e mode_i,
    output logic [W-1:0]     y_o
);
    import mpu_pkg::*;
    localparam int unsigned BYTES = W / 8;
    localparam int unsigned IDX_W = $clog2(BYTES);

    logic [IDX_W-1:0] lo_idx_d;
    logic [IDX_W-1:0] hi_idx_d;
    logic [7:0]       lo_byte_d;
    logic [7:0]       hi_byte_d;

    always_comb begin
        lo_idx_d  = IDX_W'(rot_i);
        hi_idx_d  = lo_idx_d + IDX_W'(BYTES / 2);
        lo_byte_d = b_i[{lo_idx_d, 3'b000} +: 8];
        hi_byte_d = b_i[{hi_idx_d, 3'b000} +: 8];
        case (mode_i)
            XT_PAIR: begin
                y_o = '0;
                y_o[7:0]   = lo_byte_d;
                y_o[23:16] = hi_byte_d;
            end
            XT_ACC:  y_o = a_i + W'(lo_byte_d);
            default: y_o = W'(lo_byte_d);
        endcase
    end
endmodule

// File: rtl/media_pack_unit.sv
module media_pack_unit
    import mpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  op_sel,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [4:0]  shamt,
    input  logic        shift_kind,
    input  logic [1:0]  rot_sel,
    input  logic [4:0]  sat_pos,
    output logic [31:0] res_q,
    output logic        res_valid,
    output logic        illegal_op
);
    unit_state_t st_d, st_q;

    logic [DATA_W-1:0] pack_y_d;
    logic [DATA_W-1:0] clamp_y_d;
    logic [DATA_W-1:0] ext_y_d;
    xt_mode_e          xt_mode_d;

    mpu_pack #(.W(DATA_W)) u_pack (
        .a_i(src_a), .b_i(src_b), .sh_i(shamt),
        .keep_hi_i(op_sel == OP_PACK_HI), .y_o(pack_y_d)
    );

    mpu_clamp #(.W(DATA_W)) u_clamp (
        .b_i(src_b), .sh_i(shamt), .arith_i(shift_kind),
        .pos_i(sat_pos), .y_o(clamp_y_d)
    );

    always_comb begin
        case (op_sel)
            OP_ZX_PAIR: xt_mode_d = XT_PAIR;
            OP_ZX_ACC:  xt_mode_d = XT_ACC;
            default:    xt_mode_d = XT_BYTE;
        endcase
    end

    mpu_extend #(.W(DATA_W)) u_ext (
        .a_i(src_a), .b_i(src_b), .rot_i(rot_sel),
        .mode_i(xt_mode_d), .y_o(ext_y_d)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        st_d.ill = 1'b0;
        if (req_valid) begin
            st_d.op  = op_sel;
            st_d.pos = sat_pos;
            case (op_sel)
                OP_PACK_LO, OP_PACK_HI:            st_d.res = pack_y_d;
                OP_CLAMP:                          st_d.res = clamp_y_d;
                OP_ZX_BYTE, OP_ZX_PAIR, OP_ZX_ACC: st_d.res = ext_y_d;
                default: begin
                    st_d.res = '0;
                    st_d.ill = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q      = st_q.res;
    assign res_valid  = st_q.vld;
    assign illegal_op = st_q.ill;

    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (res_valid && res_q == '0));
    a_r6_clamp_bound: assert property (@(posedge clk) disable iff (rst)
        (res_valid && st_q.op == OP_CLAMP) |-> ((res_q >> st_q.pos) == '0));
    a_r8_zext_byte_clear: assert property (@(posedge clk) disable iff (rst)
        (res_valid && st_q.op == OP_ZX_BYTE) |-> (res_q[31:8] == '0));
    a_r8_zext_pair_clear: assert property (@(posedge clk) disable iff (rst)
        (res_valid && st_q.op == OP_ZX_PAIR) |-> ((res_q & 32'hFF00_FF00) == '0));
endmodule

// File: tb/media_pack_unit_test.sv
`timescale 1ns/1ps
module media_pack_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  op_sel;
    logic [31:0] src_a, src_b;
    logic [4:0]  shamt;
    logic        shift_kind;
    logic [1:0]  rot_sel;
    logic [4:0]  sat_pos;
    logic [31:0] res_q;
    logic        res_valid;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    media_pack_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .shamt(shamt), .shift_kind(shift_kind),
        .rot_sel(rot_sel), .sat_pos(sat_pos), .res_q(res_q),
        .res_valid(res_valid), .illegal_op(illegal_op)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] sh, input logic kind, input logic [1:0] rot,
                          input logic [4:0] pos, input string req, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
        shamt = sh; shift_kind = kind; rot_sel = rot; sat_pos = pos;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, res_q, exp);
        check({req, " valid"}, {31'd0, res_valid}, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; op_sel = '0; src_a = '0; src_b = '0;
        shamt = '0; shift_kind = 1'b0; rot_sel = '0; sat_pos = '0;
        repeat (3) @(negedge clk);
        check("R1 result", res_q, 32'd0);
        check("R1 valid", {31'd0, res_valid}, 32'd0);
        check("R1 illegal", {31'd0, illegal_op}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_pack();
        run_op(3'd0, 32'h1234_5678, 32'h0000_ABCD, 5'd16, 1'b0, 2'd0, 5'd0, "R3 shift16", 32'hABCD_5678);
        run_op(3'd0, 32'h1111_2222, 32'hDEAD_BEEF, 5'd0, 1'b0, 2'd0, 5'd0, "R3 shift0", 32'hDEAD_2222);
        run_op(3'd1, 32'h1234_5678, 32'hABCD_0000, 5'd16, 1'b0, 2'd0, 5'd0, "R4 shift16", 32'h1234_ABCD);
        run_op(3'd1, 32'h1234_5678, 32'h8000_0000, 5'd0, 1'b0, 2'd0, 5'd0, "R4 shift32 neg", 32'h1234_FFFF);
        run_op(3'd1, 32'h1234_5678, 32'h7FFF_FFFF, 5'd0, 1'b0, 2'd0, 5'd0, "R4 shift32 pos", 32'h1234_0000);
        run_op(3'd1, 32'h1234_5678, 32'h0001_2345, 5'd4, 1'b0, 2'd0, 5'd0, "R4 shift4", 32'h1234_1234);
    endtask

    task automatic t_clamp();
        run_op(3'd2, 0, 32'd100, 5'd0, 1'b0, 2'd0, 5'd8, "R6 inside", 32'd100);
        run_op(3'd2, 0, 32'd300, 5'd0, 1'b0, 2'd0, 5'd8, "R6 above", 32'd255);
        run_op(3'd2, 0, 32'hFFFF_FFFB, 5'd0, 1'b0, 2'd0, 5'd8, "R6 negative", 32'd0);
        run_op(3'd2, 0, 32'd5, 5'd0, 1'b0, 2'd0, 5'd0, "R6 pos0", 32'd0);
        run_op(3'd2, 0, 32'h7FFF_FFFF, 5'd0, 1'b0, 2'd0, 5'd31, "R6 pos31", 32'h7FFF_FFFF);
        run_op(3'd2, 0, 32'h0000_0F00, 5'd4, 1'b1, 2'd0, 5'd8, "R5 asr", 32'd240);
        run_op(3'd2, 0, 32'hFFFF_0000, 5'd4, 1'b1, 2'd0, 5'd8, "R5 asr neg", 32'd0);
        run_op(3'd2, 0, 32'h0000_0010, 5'd4, 1'b0, 2'd0, 5'd8, "R5 lsl over", 32'd255);
        run_op(3'd2, 0, 32'h0000_0010, 5'd4, 1'b0, 2'd0, 5'd9, "R5 lsl fit", 32'd256);
        run_op(3'd2, 0, 32'h4000_0000, 5'd1, 1'b0, 2'd0, 5'd31, "R5 lsl into sign", 32'd0);
    endtask

    task automatic t_extend();
        logic [31:0] exp_b [4] = '{32'h44, 32'h33, 32'h22, 32'h11};
        logic [31:0] exp_p [4] = '{32'h0022_0044, 32'h0011_0033, 32'h0044_0022, 32'h0033_0011};
        for (int r = 0; r < 4; r++) begin
            run_op(3'd3, 32'hFFFF_FFFF, 32'h1122_3344, 5'd0, 1'b0, 2'(r), 5'd0, "R7 R8 byte", exp_b[r]);
            run_op(3'd4, 32'hFFFF_FFFF, 32'h1122_3344, 5'd0, 1'b0, 2'(r), 5'd0, "R7 R8 pair", exp_p[r]);
        end
        run_op(3'd5, 32'h0000_1000, 32'h1122_3344, 5'd0, 1'b0, 2'd1, 5'd0, "R9 add", 32'h0000_1033);
        run_op(3'd5, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0, 1'b0, 2'd0, 5'd0, "R9 wrap", 32'h0000_0001);
    endtask

    task automatic t_illegal();
        run_op(3'd6, 32'h5555_5555, 32'hAAAA_AAAA, 5'd3, 1'b0, 2'd1, 5'd4, "R10 code6", 32'd0);
        check("R10 flag", {31'd0, illegal_op}, 32'd1);
        @(negedge clk);
        check("R10 flag drops", {31'd0, illegal_op}, 32'd0);
        run_op(3'd7, 32'h5555_5555, 32'hAAAA_AAAA, 5'd3, 1'b0, 2'd1, 5'd4, "R10 code7", 32'd0);
        check("R10 flag7", {31'd0, illegal_op}, 32'd1);
    endtask

    task automatic t_latency();
        run_op(3'd0, 32'h0000_7777, 32'h9999_0000, 5'd0, 1'b0, 2'd0, 5'd0, "R2 issue", 32'h9999_7777);
        src_a = 32'h0; src_b = 32'h0;
        @(negedge clk);
        check("R2 valid idle", {31'd0, res_valid}, 32'd0);
        check("R2 hold", res_q, 32'h9999_7777);
    endtask

    initial begin
        t_reset();
        t_pack();
        t_clamp();
        t_extend();
        t_illegal();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule